// File: doc/BRIEF.md
# Debug Bus Command Sequencer

This block sits behind the bit-level receiver of a single-wire debug link. The receiver hands it one frame at a time, together with the acknowledge bit that closed the frame and the direction flag taken from the frame's start bit. The sequencer follows the shape of each transaction. A command frame is decoded first. A read or write command is followed by a byte-count frame, then three address frames, then the counted data bytes. The sequencer reports each stage on registered outputs.

The command phase is visible on an output, so the receiver can pick between short command frames and full byte frames. A synchronous flush input, driven by the sync-frame detector, puts the sequencer back into the command phase from any state. Only acknowledged frames advance the sequence. A frame that is not acknowledged is dropped with no trace.

Top module: `dbg_cmd_sequencer`

## Requirements
- R1: After reset, cmdPhase is 1, and addrValid, cmdValid, dataValid and txnDone are all 0.
- R2: A frame accepted in the command phase whose code (frameData[2:0]) is 0 gives, one cycle later, a one-cycle cmdValid with cmdKind 0 (system reset) together with txnDone. The sequencer stays in the command phase.
- R3: Code 1 gives cmdKind 1 (read) and code 2 gives cmdKind 2 (write), each with a one-cycle cmdValid. The sequencer then leaves the command phase (cmdPhase 0), and addrValid drops to 0. cmdValid and dataValid are never high together.
- R4: Any code from 3 to 7 gives cmdValid with cmdKind 3 (unknown). There is no txnDone, and cmdPhase stays 1.
- R5: The next accepted frame after a read or write is the byte count. The three frames after it are the address bytes, most significant first. addrOut holds the 24-bit result, and addrValid rises in the cycle after the third address byte is accepted.
- R6: In the data phase, each accepted frame gives a one-cycle dataValid with dataByte equal to the frame data. The frame that uses up the count also raises txnDone, and cmdPhase returns to 1.
- R7: dataDir equals the direction flag of the frame that produced the data byte.
- R8: A frame with frameAck 0, or with frameValid 0, changes no output and no state.
- R9: With a byte count of 0, the third address byte raises txnDone and returns the sequencer to the command phase. No dataValid follows.
- R10: A syncReset pulse returns the sequencer to the command phase from any state and clears addrValid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| syncReset | input | 1 | Synchronous flush from the sync-frame detector |
| frameValid | input | 1 | One-cycle strobe: a frame is complete |
| frameAck | input | 1 | Acknowledge bit of the frame (1 = ACK) |
| frameDir | input | 1 | Direction flag from the frame's start bit |
| frameData | input | 8 | Frame payload; command code in bits 2:0 |
| cmdPhase | output | 1 | High while the next frame is a command |
| cmdValid | output | 1 | One-cycle strobe: a command was decoded |
| cmdKind | output | 2 | 0 reset, 1 read, 2 write, 3 unknown |
| addrOut | output | 24 | Transaction address |
| addrValid | output | 1 | Address complete for the current transaction |
| dataValid | output | 1 | One-cycle strobe: a data byte was accepted |
| dataByte | output | 8 | Data byte |
| dataDir | output | 1 | Direction of the data byte |
| txnDone | output | 1 | One-cycle strobe: end of transaction |

## Verification
Some properties are checked by assertions on every cycle. An unacknowledged frame leaves the state and the remaining count untouched. The data phase is never entered with a zero count. An unknown code keeps the sequencer in the command phase, and an end strobe always returns it there. A data byte never appears without a valid address, and a flush clears the address flag. Other behaviour can only be shown by the bench's frame sequences. These are the exact byte order of the assembled address, the data values and directions, the cycle in which txnDone fires for zero and non-zero counts, and the recovery after a flush in mid-transaction.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_COUNT = 2'd1,
    ST_ADDR  = 2'd2,
    ST_DATA  = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    KIND_SRST    = 2'd0,
    KIND_READ    = 2'd1,
    KIND_WRITE   = 2'd2,
    KIND_UNKNOWN = 2'd3
  } cmdKind_t;

  // Strobes from control to datapath, all valid for one cycle.
  typedef struct packed {
    logic     flush;
    logic     cmdLoad;
    cmdKind_t kind;
    logic     addrClear;
    logic     addrShift;
    logic     addrCommit;
    logic     dataLoad;
    logic     txnEnd;
  } seqStrobes_t;

endpackage

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 3,
  parameter int CODE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              syncReset,
  input  logic              frameValid,
  input  logic              frameAck,
  input  logic [DATA_W-1:0] frameData,
  output logic              cmdPhase,
  output seqStrobes_t       strobes
);

  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);
  localparam logic [CODE_W-1:0] CODE_SRST  = CODE_W'(0);
  localparam logic [CODE_W-1:0] CODE_READ  = CODE_W'(1);
  localparam logic [CODE_W-1:0] CODE_WRITE = CODE_W'(2);

  seqState_t         state, nextState;
  logic [DATA_W-1:0] count, nextCount;
  logic [IDX_W-1:0]  addrIdx, nextIdx;
  logic              accept;
  logic [CODE_W-1:0] code;

  assign accept   = frameValid & frameAck;
  assign code     = frameData[CODE_W-1:0];
  assign cmdPhase = (state == ST_CMD);

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextCount = count;
    nextIdx   = addrIdx;
    if (syncReset) begin
      strobes.flush = 1'b1;
      nextState     = ST_CMD;
      nextCount     = '0;
      nextIdx       = '0;
    end else if (accept) begin
      unique case (state)
        ST_CMD: begin
          strobes.cmdLoad = 1'b1;
          if (code == CODE_SRST) begin
            strobes.kind   = KIND_SRST;
            strobes.txnEnd = 1'b1;
          end else if (code == CODE_READ || code == CODE_WRITE) begin
            strobes.kind      = (code == CODE_READ) ? KIND_READ : KIND_WRITE;
            strobes.addrClear = 1'b1;
            nextState         = ST_COUNT;
          end else begin
            strobes.kind = KIND_UNKNOWN;
          end
        end
        ST_COUNT: begin
          nextCount = frameData;
          nextIdx   = '0;
          nextState = ST_ADDR;
        end
        ST_ADDR: begin
          strobes.addrShift = 1'b1;
          if (addrIdx == LAST_IDX) begin
            strobes.addrCommit = 1'b1;
            if (count == '0) begin
              strobes.txnEnd = 1'b1;
              nextState      = ST_CMD;
            end else begin
              nextState = ST_DATA;
            end
          end else begin
            nextIdx = addrIdx + 1'b1;
          end
        end
        ST_DATA: begin
          strobes.dataLoad = 1'b1;
          nextCount        = count - 1'b1;
          if (count == DATA_W'(1)) begin
            strobes.txnEnd = 1'b1;
            nextState      = ST_CMD;
          end
        end
        default: nextState = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CMD;
      count   <= '0;
      addrIdx <= '0;
    end else begin
      state   <= nextState;
      count   <= nextCount;
      addrIdx <= nextIdx;
    end
  end

  // R4: an unknown code leaves the sequencer waiting for a command
  assert_unknown_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD && accept && !syncReset && code != CODE_SRST &&
     code != CODE_READ && code != CODE_WRITE) |=> (state == ST_CMD));

  // R8: a dropped frame changes neither state nor count
  assert_nack_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !syncReset) |=> ($stable(state) && $stable(count)));

  // R9: the data phase never runs with an exhausted count
  assert_count_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (count != '0));

  // R6: every end of transaction lands in the command phase
  assert_end_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.txnEnd |=> (state == ST_CMD));

  // R10: a flush always lands in the command phase
  assert_flush_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    syncReset |=> (state == ST_CMD));

endmodule

// File: rtl/dbg_seq_datapath.sv
module dbg_seq_datapath
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  seqStrobes_t                  strobes,
  input  logic                         frameDir,
  input  logic [DATA_W-1:0]            frameData,
  output logic                         cmdValid,
  output cmdKind_t                     cmdKind,
  output logic [ADDR_BYTES*DATA_W-1:0] addrOut,
  output logic                         addrValid,
  output logic                         dataValid,
  output logic [DATA_W-1:0]            dataByte,
  output logic                         dataDir,
  output logic                         txnDone
);

  localparam int ADDR_W = ADDR_BYTES * DATA_W;

  logic [ADDR_W-1:0] addrShifted;

  generate
    if (ADDR_BYTES > 1) begin : g_multi
      assign addrShifted = {addrOut[ADDR_W-DATA_W-1:0], frameData};
    end else begin : g_single
      assign addrShifted = frameData;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdValid  <= 1'b0;
      cmdKind   <= KIND_SRST;
      addrOut   <= '0;
      addrValid <= 1'b0;
      dataValid <= 1'b0;
      dataByte  <= '0;
      dataDir   <= 1'b0;
      txnDone   <= 1'b0;
    end else begin
      cmdValid  <= strobes.cmdLoad;
      dataValid <= strobes.dataLoad;
      txnDone   <= strobes.txnEnd;
      if (strobes.cmdLoad) cmdKind <= strobes.kind;
      if (strobes.addrShift) addrOut <= addrShifted;
      if (strobes.flush || strobes.addrClear) addrValid <= 1'b0;
      else if (strobes.addrCommit) addrValid <= 1'b1;
      if (strobes.dataLoad) begin
        dataByte <= frameData;
        dataDir  <= frameDir;
      end
    end
  end

  // R3: command and data events never coincide
  assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmdValid, dataValid}));

  // R6: data bytes only follow a completed address
  assert_data_after_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> addrValid);

  // R5: the last address byte marks the address valid
  assert_commit_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.addrCommit |=> addrValid);

  // R10: a flush clears the address flag and suppresses events
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.flush |=> (!addrValid && !dataValid && !cmdValid && !txnDone));

endmodule

// File: rtl/dbg_cmd_sequencer.sv
module dbg_cmd_sequencer
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 3,
  parameter int CODE_W     = 3,
  localparam int ADDR_W    = ADDR_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              syncReset,
  input  logic              frameValid,
  input  logic              frameAck,
  input  logic              frameDir,
  input  logic [DATA_W-1:0] frameData,
  output logic              cmdPhase,
  output logic              cmdValid,
  output logic [1:0]        cmdKind,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataByte,
  output logic              dataDir,
  output logic              txnDone
);

  seqStrobes_t strobes;
  cmdKind_t    kindReg;

  dbg_seq_ctrl #(
    .DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES), .CODE_W(CODE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .syncReset(syncReset),
    .frameValid(frameValid), .frameAck(frameAck), .frameData(frameData),
    .cmdPhase(cmdPhase), .strobes(strobes)
  );

  dbg_seq_datapath #(
    .DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .frameDir(frameDir), .frameData(frameData),
    .cmdValid(cmdValid), .cmdKind(kindReg), .addrOut(addrOut),
    .addrValid(addrValid), .dataValid(dataValid), .dataByte(dataByte),
    .dataDir(dataDir), .txnDone(txnDone)
  );

  assign cmdKind = kindReg;

endmodule

// File: tb/tb_dbg_cmd_sequencer.sv
module tb_dbg_cmd_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        syncReset = 1'b0;
  logic        frameValid = 1'b0;
  logic        frameAck = 1'b0;
  logic        frameDir = 1'b0;
  logic [7:0]  frameData = '0;
  logic        cmdPhase, cmdValid, addrValid, dataValid, dataDir, txnDone;
  logic [1:0]  cmdKind;
  logic [23:0] addrOut;
  logic [7:0]  dataByte;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dbg_cmd_sequencer dut (
    .clk(clk), .rst_n(rst_n), .syncReset(syncReset),
    .frameValid(frameValid), .frameAck(frameAck), .frameDir(frameDir),
    .frameData(frameData), .cmdPhase(cmdPhase), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .addrOut(addrOut), .addrValid(addrValid),
    .dataValid(dataValid), .dataByte(dataByte), .dataDir(dataDir),
    .txnDone(txnDone)
  );

  // {ack, dir, data[7:0], expCmdValid, expKind[1:0], expDataValid, expDone, expPhase}
  localparam int NVEC = 17;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h01, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0},  // read
    {1'b1, 1'b0, 8'h02, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // count 2
    {1'b1, 1'b0, 8'h12, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // addr E
    {1'b0, 1'b0, 8'hFF, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // nack
    {1'b1, 1'b0, 8'h34, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // addr H
    {1'b1, 1'b0, 8'h56, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // addr L
    {1'b1, 1'b1, 8'hA5, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0},  // data 1
    {1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // nack
    {1'b1, 1'b1, 8'h3C, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1},  // data 2, end
    {1'b1, 1'b0, 8'h05, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1},  // unknown
    {1'b1, 1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1},  // system reset
    {1'b1, 1'b0, 8'h02, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},  // write
    {1'b1, 1'b0, 8'h01, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // count 1
    {1'b1, 1'b0, 8'hAB, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hCD, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hEF, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h77, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1}   // data, end
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic sendFrame(input logic ack, input logic dir, input logic [7:0] data);
    @(negedge clk);
    frameValid = 1'b1; frameAck = ack; frameDir = dir; frameData = data;
    @(negedge clk);
    frameValid = 1'b0; frameAck = 1'b0;
  endtask

  task automatic pulseSync();
    @(negedge clk);
    syncReset = 1'b1;
    @(negedge clk);
    syncReset = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cmdPhase == 1'b1, "R1", "cmdPhase", cmdPhase, 1);
    check({addrValid, cmdValid, dataValid, txnDone} == 4'b0, "R1", "flags",
          {addrValid, cmdValid, dataValid, txnDone}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      sendFrame(v[15], v[14], v[13:6]);
      // R2 R3 R4: command decode; R8: nack rows expect no events
      check(cmdValid == v[5], "R8", "cmdValid", cmdValid, v[5]);
      if (v[5]) check(cmdKind == v[4:3], "R3", "cmdKind", cmdKind, v[4:3]);
      check(dataValid == v[2], "R6", "dataValid", dataValid, v[2]);
      check(txnDone == v[1], "R6", "txnDone", txnDone, v[1]);
      check(cmdPhase == v[0], "R4", "cmdPhase", cmdPhase, v[0]);
      if (v[2]) begin
        check(dataByte == v[13:6], "R6", "dataByte", dataByte, v[13:6]);
        check(dataDir == v[14], "R7", "dataDir", dataDir, v[14]);
      end
      if (i == 4) check(addrValid == 1'b0, "R5", "addrValid early", addrValid, 0);
      if (i == 5 || i == 8) begin
        check(addrOut == 24'h123456, "R5", "addrOut", addrOut, 24'h123456);
        check(addrValid == 1'b1, "R5", "addrValid", addrValid, 1);
      end
      if (i == 11) check(addrValid == 1'b0, "R3", "addrValid cleared", addrValid, 0);
      if (i == 15) check(addrOut == 24'hABCDEF, "R5", "addrOut", addrOut, 24'hABCDEF);
    end

    // R2: reset command with a high upper nibble is still code 0
    sendFrame(1'b1, 1'b0, 8'hF8);
    check(cmdValid && cmdKind == 2'd0 && txnDone && cmdPhase, "R2", "srst upper bits",
          {cmdValid, cmdKind, txnDone, cmdPhase}, 5'b10011);

    // R8: frameValid low with ack high does nothing
    @(negedge clk);
    frameValid = 1'b0; frameAck = 1'b1; frameData = 8'h01;
    @(negedge clk);
    frameAck = 1'b0;
    check(!cmdValid && cmdPhase, "R8", "invalid frame", {cmdValid, cmdPhase}, 2'b01);

    // R9: zero count
    sendFrame(1'b1, 1'b0, 8'h01);
    sendFrame(1'b1, 1'b0, 8'h00);
    sendFrame(1'b1, 1'b0, 8'h0A);
    sendFrame(1'b1, 1'b0, 8'h0B);
    check(!txnDone && !cmdPhase, "R9", "not done mid-address", {txnDone, cmdPhase}, 0);
    sendFrame(1'b1, 1'b0, 8'h0C);
    check(txnDone && cmdPhase && !dataValid, "R9", "zero count end",
          {txnDone, cmdPhase, dataValid}, 3'b110);
    check(addrOut == 24'h0A0B0C && addrValid, "R9", "addr zero count", addrOut, 24'h0A0B0C);
    sendFrame(1'b1, 1'b1, 8'h02);
    check(cmdValid && cmdKind == 2'd2 && !dataValid, "R9", "next frame is command",
          {cmdValid, cmdKind, dataValid}, 4'b1100);

    // R10: flush mid-address
    sendFrame(1'b1, 1'b0, 8'h03);
    sendFrame(1'b1, 1'b0, 8'h11);
    pulseSync();
    check(cmdPhase && !addrValid, "R10", "flush mid address", {cmdPhase, addrValid}, 2'b10);
    sendFrame(1'b1, 1'b0, 8'h07);
    check(cmdValid && cmdKind == 2'd3 && cmdPhase, "R4", "unknown after flush",
          {cmdValid, cmdKind, cmdPhase}, 4'b1111);

    // R10: flush after a complete address clears addrValid
    sendFrame(1'b1, 1'b0, 8'h01);
    sendFrame(1'b1, 1'b0, 8'h00);
    sendFrame(1'b1, 1'b0, 8'h01);
    sendFrame(1'b1, 1'b0, 8'h02);
    sendFrame(1'b1, 1'b0, 8'h03);
    check(addrValid == 1'b1, "R5", "addrValid set", addrValid, 1);
    pulseSync();
    check(addrValid == 1'b0, "R10", "flush clears addrValid", addrValid, 0);

    // R1: asynchronous reset mid-transaction
    sendFrame(1'b1, 1'b0, 8'h02);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmdPhase && !addrValid && !cmdValid, "R1", "reset mid transaction",
          {cmdPhase, addrValid, cmdValid}, 3'b100);

    finish();
  end

endmodule